// File: doc/BRIEF.md
# Sync Polarity Detector and Corrector

This block takes two single-bit sync streams that are already sampled into the clock domain. One is a line (or composite) sync and the other is a separate frame sync. Each may arrive with either polarity. The block works out which level of each stream is the active pulse. It does this by integrating the stream slowly over many lines: the level present for a minority of the time is treated as the pulse. It then presents both syncs as active-high signals, together with a flag per input that reports the detected input polarity.

A line sync pulse is only passed on once it has lasted a minimum width, so narrow glitches never reach the corrected output. While the corrected line sync stays active long enough to be a broad frame pulse, the block raises a separate composite-frame output. When the separate frame input stays low for a long quiet interval, the corrected frame sync is taken from that composite-frame output instead.

All widths, thresholds and time constants are parameters counted in clock cycles, so one design serves any pixel clock.

Top module: `spd_top`

## Requirements
- R1: After reset both polarity flags read 0 (input assumed active-low), and hsync_o, vsync_o and csync_v_o stay 0 until the matching input has been classified.
- R2: The line polarity integrator is a counter from 0 to 2^CNT_W-1 that starts at 2^(CNT_W-1). Once every H_PRESC cycles it steps up when the synchronised input is high and down when it is low, and it saturates at both ends. hpol_o becomes 1 (input active-high) when the counter is at or below LO_TH, and 0 when it is at or above HI_TH; between the thresholds it holds.
- R3: hsync_o is 1 in a cycle only when the active input level has been present for at least MIN_W consecutive cycles. An active run shorter than MIN_W produces no output pulse.
- R4: The frame input has its own integrator with the same thresholds and prescale V_PRESC. It drives vpol_o with the same encoding (1 = active-high) and the same hysteresis.
- R5: csync_v_o is 1 while the corrected line sync has been active for at least VINT_W consecutive cycles, and it drops with the end of that active run.
- R6: When the synchronised frame input has been low for V_QUIET consecutive cycles, vsync_o equals csync_v_o. A high sample on the frame input returns vsync_o to the corrected separate frame sync.
- R7: Each input passes a two-flop synchroniser, so a change on hsync_i or vsync_i first affects the registered outputs three clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Line or composite sync, either polarity |
| vsync_i | input | 1 | Separate frame sync, either polarity, held low when unused |
| hsync_o | output | 1 | Corrected active-high line sync |
| vsync_o | output | 1 | Corrected active-high frame sync |
| csync_v_o | output | 1 | Frame pulse recovered from broad composite pulses |
| hpol_o | output | 1 | Detected line input polarity, 1 = active-high |
| vpol_o | output | 1 | Detected frame input polarity, 1 = active-high |

## Verification
The hardest state to reach from the ports is a polarity reversal. The integrator must first leave one saturated end and cross the far threshold, and the output must stay correct through that interval. The stimulus therefore runs long phases of one polarity until the counter saturates, then flips polarity mid-stream. The composite path is also hard to reach: it needs the frame input silenced for longer than the quiet limit while broad line pulses arrive, and then a return to separate sync. The cycle-level model in the bench follows every one of these transitions.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic {
        POL_ACT_LOW  = 1'b0,
        POL_ACT_HIGH = 1'b1
    } spd_pol_e;

endpackage

// File: rtl/spd_sync2.sv
module spd_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] safe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = d_i;
        st_d.safe = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.safe;

endmodule

// File: rtl/spd_pol_integ.sv
module spd_pol_integ
    import spd_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int LO_TH = 256,
    parameter int HI_TH = 767,
    parameter int PRESC = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    output spd_pol_e         pol_o,
    output logic             dec_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] LO_LIM  = CNT_W'(LO_TH);
    localparam logic [CNT_W-1:0] HI_LIM  = CNT_W'(HI_TH);

    logic tick;

    generate
        if (PRESC <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PRESC);
            localparam logic [PW-1:0] PRE_LAST = PW'(PRESC - 1);
            logic [PW-1:0] pre_d, pre_q;
            always_comb begin
                pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end
            assign tick = (pre_q == PRE_LAST);
        end
    endgenerate

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        spd_pol_e         pol;
        logic             dec;
    } integ_st_t;

    integ_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (lvl_i && st_q.cnt != CNT_TOP)
                st_d.cnt = st_q.cnt + 1'b1;
            else if (!lvl_i && st_q.cnt != '0)
                st_d.cnt = st_q.cnt - 1'b1;
        end
        // minority-high input drives the count low: pulse is the high level
        if (st_q.cnt <= LO_LIM) begin
            st_d.pol = POL_ACT_HIGH;
            st_d.dec = 1'b1;
        end else if (st_q.cnt >= HI_LIM) begin
            st_d.pol = POL_ACT_LOW;
            st_d.dec = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_MID;
            st_q.pol <= POL_ACT_LOW;
            st_q.dec <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol_o = st_q.pol;
    assign dec_o = st_q.dec;
    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/spd_width_qual.sv
module spd_width_qual #(
    parameter int MIN_W  = 175,
    parameter int VINT_W = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic hs_o,
    output logic cv_o,
    output logic cv_next_o
);

    localparam int RUN_MAX = (MIN_W > VINT_W) ? MIN_W : VINT_W;
    localparam int RW      = $clog2(RUN_MAX + 1);
    localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);
    localparam logic [RW-1:0] MIN_LIM = RW'(MIN_W);
    localparam logic [RW-1:0] VINT_LIM = RW'(VINT_W);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          hs;
        logic          cv;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!act_i)
            st_d.run = '0;
        else if (st_q.run != RUN_TOP)
            st_d.run = st_q.run + 1'b1;
        st_d.hs = act_i && (st_d.run >= MIN_LIM);
        st_d.cv = act_i && (st_d.run >= VINT_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_o      = st_q.hs;
    assign cv_o      = st_q.cv;
    assign cv_next_o = st_d.cv;

endmodule

// File: rtl/spd_top.sv
module spd_top
    import spd_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int LO_TH   = 256,
    parameter int HI_TH   = 767,
    parameter int H_PRESC = 128,
    parameter int V_PRESC = 4096,
    parameter int MIN_W   = 175,
    parameter int VINT_W  = 2500,
    parameter int V_QUIET = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_i,
    input  logic vsync_i,
    output logic hsync_o,
    output logic vsync_o,
    output logic csync_v_o,
    output logic hpol_o,
    output logic vpol_o
);

    localparam int QW = $clog2(V_QUIET + 1);
    localparam logic [QW-1:0] QUIET_LIM = QW'(V_QUIET);

    logic [1:0]       sync_s;
    logic             h_s, v_s;
    spd_pol_e         h_pol, v_pol;
    logic             h_dec, v_dec;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             h_act, v_act;
    logic             cv_next;
    logic             v_absent;

    spd_sync2 #(.W(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({vsync_i, hsync_i}),
        .q_o   (sync_s)
    );
    assign h_s = sync_s[0];
    assign v_s = sync_s[1];

    spd_pol_integ #(
        .CNT_W (CNT_W), .LO_TH (LO_TH), .HI_TH (HI_TH), .PRESC (H_PRESC)
    ) h_integ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (h_s),
        .pol_o (h_pol),
        .dec_o (h_dec),
        .cnt_o (h_cnt)
    );

    spd_pol_integ #(
        .CNT_W (CNT_W), .LO_TH (LO_TH), .HI_TH (HI_TH), .PRESC (V_PRESC)
    ) v_integ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (v_s),
        .pol_o (v_pol),
        .dec_o (v_dec),
        .cnt_o (v_cnt)
    );

    assign h_act = h_dec && ((h_pol == POL_ACT_HIGH) ? h_s : ~h_s);
    assign v_act = v_dec && ((v_pol == POL_ACT_HIGH) ? v_s : ~v_s);

    spd_width_qual #(.MIN_W (MIN_W), .VINT_W (VINT_W)) qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (h_act),
        .hs_o      (hsync_o),
        .cv_o      (csync_v_o),
        .cv_next_o (cv_next)
    );

    typedef struct packed {
        logic [QW-1:0] quiet;
        logic          vs;
    } top_st_t;

    top_st_t st_d, st_q;

    assign v_absent = (st_q.quiet == QUIET_LIM);

    always_comb begin
        st_d = st_q;
        if (v_s)
            st_d.quiet = '0;
        else if (!v_absent)
            st_d.quiet = st_q.quiet + 1'b1;
        st_d.vs = v_absent ? cv_next : v_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vsync_o = st_q.vs;
    assign hpol_o  = (h_pol == POL_ACT_HIGH);
    assign vpol_o  = (v_pol == POL_ACT_HIGH);

endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
    parameter int CNT_W = 10,
    parameter int LO_TH = 256,
    parameter int HI_TH = 767
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             csync_v_o,
    input logic             hpol_o,
    input logic             vpol_o,
    input logic             h_dec,
    input logic             v_dec,
    input logic             h_act,
    input logic             v_absent,
    input logic [CNT_W-1:0] h_cnt,
    input logic [CNT_W-1:0] v_cnt
);

    localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(LO_TH);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HI_TH);

    // R1: no corrected line pulse before the line input is classified
    a_r1_h_idle_undecided: assert property (@(posedge clk) disable iff (!rst_n)
        !h_dec |=> !hsync_o);

    // R1: no frame pulse before classification unless composite routing is active
    a_r1_v_idle_undecided: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_dec && !v_absent) |=> !vsync_o);

    // R2: line flag only changes after the counter sat at a threshold
    a_r2_hpol_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (hpol_o != $past(hpol_o)) |-> ($past(h_cnt) <= LO_LIM || $past(h_cnt) >= HI_LIM));

    // R4: frame flag only changes after its counter sat at a threshold
    a_r4_vpol_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (vpol_o != $past(vpol_o)) |-> ($past(v_cnt) <= LO_LIM || $past(v_cnt) >= HI_LIM));

    // R3: a corrected line pulse starts only from an active input level
    a_r3_rise_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) |-> $past(h_act));

    // R5: the recovered frame pulse sits inside a corrected line pulse
    a_r5_cv_inside_h: assert property (@(posedge clk) disable iff (!rst_n)
        csync_v_o |-> hsync_o);

    // R6: in composite routing the frame output copies the recovered pulse
    a_r6_composite_route: assert property (@(posedge clk) disable iff (!rst_n)
        v_absent |=> (vsync_o == csync_v_o));

endmodule

bind spd_top spd_checker #(
    .CNT_W (CNT_W), .LO_TH (LO_TH), .HI_TH (HI_TH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .csync_v_o (csync_v_o),
    .hpol_o    (hpol_o),
    .vpol_o    (vpol_o),
    .h_dec     (h_dec),
    .v_dec     (v_dec),
    .h_act     (h_act),
    .v_absent  (v_absent),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt)
);

// File: tb/spd_top_tb_top.sv
module spd_top_tb_top;

    localparam int CNT_W   = 6;
    localparam int CNT_MAX = 63;
    localparam int LO_TH   = 16;
    localparam int HI_TH   = 47;
    localparam int H_PRESC = 2;
    localparam int V_PRESC = 4;
    localparam int MIN_W   = 4;
    localparam int VINT_W  = 12;
    localparam int V_QUIET = 400;
    localparam int LINE    = 40;
    localparam int FRAME   = 1000;
    localparam int VW      = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_i = 1'b1;
    logic vsync_i = 1'b1;
    logic hsync_o, vsync_o, csync_v_o, hpol_o, vpol_o;

    always #2 clk = ~clk;

    spd_top #(
        .CNT_W (CNT_W), .LO_TH (LO_TH), .HI_TH (HI_TH),
        .H_PRESC (H_PRESC), .V_PRESC (V_PRESC),
        .MIN_W (MIN_W), .VINT_W (VINT_W), .V_QUIET (V_QUIET)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .hsync_i (hsync_i), .vsync_i (vsync_i),
        .hsync_o (hsync_o), .vsync_o (vsync_o), .csync_v_o (csync_v_o),
        .hpol_o (hpol_o), .vpol_o (vpol_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit cmp_en   = 1'b0;

    // stimulus configuration
    bit h_high = 1'b0, v_high = 1'b0, v_off = 1'b0, broad = 1'b0;
    int h_w = 6;
    int cyc = 0;

    // behavioural reference state
    int hq[$];
    int vq[$];
    int m_hcnt, m_vcnt, m_hpre, m_vpre, m_run, m_quiet;
    bit m_hpol, m_vpol, m_hdec, m_vdec;
    bit e_h, e_v, e_cv;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model: integrate, classify, qualify, route
    always @(posedge clk) begin
        if (!rst_n) begin
            hq = '{0, 0};
            vq = '{0, 0};
            m_hcnt = 1 << (CNT_W - 1); m_vcnt = 1 << (CNT_W - 1);
            m_hpre = 0; m_vpre = 0; m_run = 0; m_quiet = 0;
            m_hpol = 0; m_vpol = 0; m_hdec = 0; m_vdec = 0;
            e_h = 0; e_v = 0; e_cv = 0;
        end else begin
            int hs, vs, nh, nv, nrun, nq;
            bit ha, va, absent;
            hs = hq.pop_front(); hq.push_back(int'(hsync_i));
            vs = vq.pop_front(); vq.push_back(int'(vsync_i));
            ha = m_hdec && ((hs != 0) == m_hpol);
            va = m_vdec && ((vs != 0) == m_vpol);
            absent = (m_quiet >= V_QUIET);
            nh = m_hcnt;
            if (m_hpre == H_PRESC - 1) nh = hs ? ((m_hcnt < CNT_MAX) ? m_hcnt + 1 : CNT_MAX)
                                              : ((m_hcnt > 0) ? m_hcnt - 1 : 0);
            nv = m_vcnt;
            if (m_vpre == V_PRESC - 1) nv = vs ? ((m_vcnt < CNT_MAX) ? m_vcnt + 1 : CNT_MAX)
                                              : ((m_vcnt > 0) ? m_vcnt - 1 : 0);
            if (m_hcnt <= LO_TH) begin m_hpol = 1; m_hdec = 1; end
            else if (m_hcnt >= HI_TH) begin m_hpol = 0; m_hdec = 1; end
            if (m_vcnt <= LO_TH) begin m_vpol = 1; m_vdec = 1; end
            else if (m_vcnt >= HI_TH) begin m_vpol = 0; m_vdec = 1; end
            nrun = ha ? ((m_run < VINT_W) ? m_run + 1 : VINT_W) : 0;
            nq = vs ? 0 : ((m_quiet < V_QUIET) ? m_quiet + 1 : V_QUIET);
            e_h  = ha && (nrun >= MIN_W);
            e_cv = ha && (nrun >= VINT_W);
            e_v  = absent ? e_cv : va;
            m_hcnt = nh; m_vcnt = nv; m_run = nrun; m_quiet = nq;
            m_hpre = (m_hpre == H_PRESC - 1) ? 0 : m_hpre + 1;
            m_vpre = (m_vpre == V_PRESC - 1) ? 0 : m_vpre + 1;
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check(hsync_o == e_h,    "R3,R7 hsync_o", hsync_o, e_h);
            check(csync_v_o == e_cv, "R5 csync_v_o",  csync_v_o, e_cv);
            check(vsync_o == e_v,    "R6 vsync_o",    vsync_o, e_v);
            check(hpol_o == m_hpol,  "R2 hpol_o",     hpol_o, m_hpol);
            check(vpol_o == m_vpol,  "R4 vpol_o",     vpol_o, m_vpol);
        end
    end

    task automatic drive(input int n);
        for (int i = 0; i < n; i++) begin
            int lp, fp, w;
            bit ha, va;
            @(negedge clk);
            lp = cyc % LINE;
            fp = cyc % FRAME;
            w  = (broad && fp < 3 * LINE) ? 20 : h_w;
            ha = (lp < w);
            va = (fp < VW);
            hsync_i = h_high ? ha : !ha;
            vsync_i = v_off ? 1'b0 : (v_high ? va : !va);
            cyc++;
        end
    endtask

    int seen_h, seen_cv, route_bad;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1: reset state before any classification
        check(hpol_o == 0 && vpol_o == 0, "R1 flags after reset", {hpol_o, vpol_o}, 0);
        check(hsync_o == 0 && vsync_o == 0 && csync_v_o == 0, "R1 outputs idle",
              {hsync_o, vsync_o, csync_v_o}, 0);
        // phase 1: both inputs active-low
        drive(6000);
        check(hpol_o == 0, "R2 active-low line input", hpol_o, 0);
        check(vpol_o == 0, "R4 active-low frame input", vpol_o, 0);
        // phase 2: line polarity flips
        h_high = 1'b1;
        drive(4000);
        check(hpol_o == 1, "R2 line flip to active-high", hpol_o, 1);
        // phase 3: frame polarity flips
        v_high = 1'b1;
        drive(4000);
        check(vpol_o == 1, "R4 frame flip to active-high", vpol_o, 1);
        // phase 4: frame input silent, broad composite pulses
        v_off = 1'b1; broad = 1'b1;
        seen_cv = 0; route_bad = 0;
        for (int k = 0; k < 5000; k++) begin
            drive(1);
            if (csync_v_o) seen_cv++;
            if (k > V_QUIET + 10 && vsync_o != csync_v_o) route_bad++;
        end
        check(seen_cv > 0, "R5 composite frame pulse seen", seen_cv, 1);
        check(route_bad == 0, "R6 frame output follows composite", route_bad, 0);
        // phase 5: only sub-minimum line pulses
        broad = 1'b0; h_w = 2;
        drive(200);
        seen_h = 0;
        for (int k = 0; k < 1000; k++) begin
            drive(1);
            if (hsync_o) seen_h++;
        end
        check(seen_h == 0, "R3 narrow pulses suppressed", seen_h, 0);
        // phase 6: separate frame sync returns, active-low
        h_w = 6; v_off = 1'b0; v_high = 1'b0;
        drive(3000);
        check(vpol_o == 0, "R4 frame flip back to active-low", vpol_o, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule